// File: doc/BRIEF.md
# Ordered Write-Read-Write Sequencer

This block is a master-side controller for an AXI4 port. After one start pulse it writes a first value to an address, reads that address back, and writes a second value to the same address. Every step is a single-beat transaction. The AXI4 read and write channels carry no ordering relation to each other, so the block enforces the order itself. The read address goes out only after the first write's response has been accepted. The second write goes out only after the final read-data beat has been accepted.

The caller supplies the address, both write values and a byte-strobe mask together with the start pulse. The block returns the data it read back and an error flag. It then marks the end of the sequence with a one-cycle done pulse. A busy level covers the sequence while it runs. A response other than OKAY on either response path stops the sequence at that point.

Top module: `ordered_wrw_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every VALID and READY output is low, and busy, done and err are low.
- R2: A start pulse accepted while idle raises awvalid and wvalid in the next cycle. The address is the start address and the data is the first write value under the given strobe mask. awlen is 0, awsize is log2 of the data bus width in bytes, awburst is 2'b01 (incrementing), and wlast is 1.
- R3: Once awvalid, wvalid or arvalid is high, it stays high with an unchanged address or data until the cycle in which the matching READY is high.
- R4: arvalid rises only in the cycle after the B handshake (bvalid and bready both high) of the first write. araddr is the start address and arlen is 0.
- R5: bready is high only after both the AW and the W transfer of the current write have been accepted. rready is high only after the AR transfer has been accepted.
- R6: awvalid rises for the second write only in the cycle after an R handshake with rlast high. That write uses the same address and strobe mask and carries the second write value.
- R7: rd_data takes rdata in the cycle after the R handshake with rlast high, whether or not that response is an error. It holds that value until the next read.
- R8: With the default STRICT_OKAY=1, any bresp or rresp other than 2'b00 sets err, ends the sequence in the next cycle and issues no further transaction. With STRICT_OKAY=0, only responses with bit 1 set count as errors.
- R9: done is high for exactly one cycle per sequence. busy is high from the cycle after the accepted start until the cycle in which done rises, and busy is low whenever done is high.
- R10: err stays set after an error until the next accepted start, which clears it.
- R11: A start pulse while busy is ignored. The running sequence keeps its address and data, and no extra transaction follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| start_addr | input | ADDR_W | Target address |
| wval_first | input | DATA_W | Value for the first write |
| wval_second | input | DATA_W | Value for the second write |
| wmask | input | DATA_W/8 | Byte-strobe mask used by both writes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Error response seen in the last sequence |
| rd_data | output | DATA_W | Data captured from the read |
| awvalid | output | 1 | Write-address valid |
| awready | input | 1 | Write-address ready |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Beat count minus one (always 0) |
| awsize | output | 3 | Bytes per beat, log2 encoded |
| awburst | output | 2 | Burst type (incrementing) |
| wvalid | output | 1 | Write-data valid |
| wready | input | 1 | Write-data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Last write beat (always 1) |
| bvalid | input | 1 | Write-response valid |
| bready | output | 1 | Write-response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read-address valid |
| arready | input | 1 | Read-address ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Beat count minus one (always 0) |
| arsize | output | 3 | Bytes per beat, log2 encoded |
| arburst | output | 2 | Burst type (incrementing) |
| rvalid | input | 1 | Read-data valid |
| rready | output | 1 | Read-data ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat |

## Verification
The bound checker checks the following rules in every cycle:
- VALID and its payload stay stable until READY.
- arvalid and the second awvalid appear only right after the B handshake and the final R handshake that must come before them.
- The two response READYs never overlap an outstanding request.
- done is a one-cycle pulse that never coincides with busy.
- An error response ends the sequence with err set.

Only the directed scenarios show the rest. These cover the full event order and every payload value against a slave model with varied ready and response delays. They also cover the error abort at each of the three response points, the clearing of err by the next start, and a start pulse ignored in the middle of a sequence.

// File: rtl/wrw_pkg.sv
package wrw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREQ,
      ST_WRSP,
      ST_RREQ,
      ST_RRSP
   } wrw_state_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam logic [7:0] LEN_SINGLE = 8'd0;
endpackage

// File: rtl/wrw_vhold.sv
module wrw_vhold (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic accept,
   output logic vld
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         vld <= 1'b0;
      else if (launch)
         vld <= 1'b1;
      else if (vld && accept)
         vld <= 1'b0;
   end
endmodule

// File: rtl/wrw_resp_chk.sv
module wrw_resp_chk #(
   parameter bit STRICT_OKAY = 1'b1
) (
   input  logic [1:0] resp,
   output logic       bad
);
   generate
      if (STRICT_OKAY) begin : g_strict
         assign bad = (resp != wrw_pkg::RESP_OKAY);
      end else begin : g_loose
         assign bad = resp[1];
      end
   endgenerate
endmodule

// File: rtl/wrw_ctrl.sv
module wrw_ctrl
   import wrw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic awvalid,
   input  logic wvalid,
   input  logic aw_hs,
   input  logic w_hs,
   input  logic b_hs,
   input  logic b_bad,
   input  logic ar_hs,
   input  logic r_hs,
   input  logic r_end,
   input  logic r_bad,
   output logic load,
   output logic launch_wr,
   output logic launch_rd,
   output logic cap_rd,
   output logic second,
   output logic busy,
   output logic done,
   output logic err,
   output logic bready,
   output logic rready
);
   wrw_state_e state_q, state_d;
   logic       finish, fail;

   always_comb begin
      state_d   = state_q;
      load      = 1'b0;
      launch_wr = 1'b0;
      launch_rd = 1'b0;
      cap_rd    = 1'b0;
      finish    = 1'b0;
      fail      = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            state_d   = ST_WREQ;
            load      = 1'b1;
            launch_wr = 1'b1;
         end
         ST_WREQ: if ((!awvalid || aw_hs) && (!wvalid || w_hs))
            state_d = ST_WRSP;
         ST_WRSP: if (b_hs) begin
            if (b_bad || second) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
               fail    = b_bad;
            end else begin
               state_d   = ST_RREQ;
               launch_rd = 1'b1;
            end
         end
         ST_RREQ: if (ar_hs)
            state_d = ST_RRSP;
         ST_RRSP: if (r_hs && r_end) begin
            cap_rd = 1'b1;
            if (r_bad) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
               fail    = 1'b1;
            end else begin
               state_d   = ST_WREQ;
               launch_wr = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         second  <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= finish;
         if (load)
            second <= 1'b0;
         else if (launch_wr)
            second <= 1'b1;
         if (load)
            err <= 1'b0;
         else if (fail)
            err <= 1'b1;
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign bready = (state_q == ST_WRSP);
   assign rready = (state_q == ST_RRSP);
endmodule

// File: rtl/ordered_wrw_seq.sv
module ordered_wrw_seq
   import wrw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit STRICT_OKAY = 1'b1,
   localparam int STRB_W     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] wval_first,
   input  logic [DATA_W-1:0] wval_second,
   input  logic [STRB_W-1:0] wmask,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic              awvalid,
   input  logic              awready,
   output logic [ADDR_W-1:0] awaddr,
   output logic [7:0]        awlen,
   output logic [2:0]        awsize,
   output logic [1:0]        awburst,
   output logic              wvalid,
   input  logic              wready,
   output logic [DATA_W-1:0] wdata,
   output logic [STRB_W-1:0] wstrb,
   output logic              wlast,
   input  logic              bvalid,
   output logic              bready,
   input  logic [1:0]        bresp,
   output logic              arvalid,
   input  logic              arready,
   output logic [ADDR_W-1:0] araddr,
   output logic [7:0]        arlen,
   output logic [2:0]        arsize,
   output logic [1:0]        arburst,
   input  logic              rvalid,
   output logic              rready,
   input  logic [DATA_W-1:0] rdata,
   input  logic [1:0]        rresp,
   input  logic              rlast
);
   localparam int          NCH      = 3;
   localparam logic [2:0]  SIZE_ENC = 3'($clog2(STRB_W));

   generate
      if (DATA_W < 8 || DATA_W > 1024 || (DATA_W % 8) != 0 || (STRB_W & (STRB_W - 1)) != 0) begin : g_bad_data_w
         $error("ordered_wrw_seq: DATA_W must be 8..1024 bits with a power-of-two byte count");
      end
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ordered_wrw_seq: ADDR_W must be 1..64");
      end
   endgenerate

   logic              load, launch_wr, launch_rd, cap_rd, second;
   logic              b_bad, r_bad;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] val0_q, val1_q;
   logic [STRB_W-1:0] mask_q;
   logic [NCH-1:0]    ch_launch, ch_accept, ch_vld;

   assign ch_launch = {launch_rd, launch_wr, launch_wr};
   assign ch_accept = {arready, wready, awready};

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      wrw_vhold u_hold (
         .clk    (clk),
         .rst_n  (rst_n),
         .launch (ch_launch[g]),
         .accept (ch_accept[g]),
         .vld    (ch_vld[g])
      );
   end

   assign awvalid = ch_vld[0];
   assign wvalid  = ch_vld[1];
   assign arvalid = ch_vld[2];

   wrw_resp_chk #(.STRICT_OKAY(STRICT_OKAY)) u_bchk (.resp(bresp), .bad(b_bad));
   wrw_resp_chk #(.STRICT_OKAY(STRICT_OKAY)) u_rchk (.resp(rresp), .bad(r_bad));

   wrw_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .awvalid   (awvalid),
      .wvalid    (wvalid),
      .aw_hs     (awvalid && awready),
      .w_hs      (wvalid && wready),
      .b_hs      (bvalid && bready),
      .b_bad     (b_bad),
      .ar_hs     (arvalid && arready),
      .r_hs      (rvalid && rready),
      .r_end     (rlast),
      .r_bad     (r_bad),
      .load      (load),
      .launch_wr (launch_wr),
      .launch_rd (launch_rd),
      .cap_rd    (cap_rd),
      .second    (second),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .bready    (bready),
      .rready    (rready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         val0_q  <= '0;
         val1_q  <= '0;
         mask_q  <= '0;
         rd_data <= '0;
      end else begin
         if (load) begin
            addr_q <= start_addr;
            val0_q <= wval_first;
            val1_q <= wval_second;
            mask_q <= wmask;
         end
         if (cap_rd)
            rd_data <= rdata;
      end
   end

   assign awaddr  = addr_q;
   assign araddr  = addr_q;
   assign awlen   = LEN_SINGLE;
   assign arlen   = LEN_SINGLE;
   assign awsize  = SIZE_ENC;
   assign arsize  = SIZE_ENC;
   assign awburst = BURST_INCR;
   assign arburst = BURST_INCR;
   assign wdata   = second ? val1_q : val0_q;
   assign wstrb   = mask_q;
   assign wlast   = 1'b1;
endmodule

// File: rtl/wrw_seq_chk.sv
module wrw_seq_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit STRICT_OKAY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [DATA_W-1:0] rd_data,
   input logic              awvalid,
   input logic              awready,
   input logic [ADDR_W-1:0] awaddr,
   input logic [7:0]        awlen,
   input logic              wvalid,
   input logic              wready,
   input logic [DATA_W-1:0] wdata,
   input logic              wlast,
   input logic              bvalid,
   input logic              bready,
   input logic [1:0]        bresp,
   input logic              arvalid,
   input logic              arready,
   input logic [ADDR_W-1:0] araddr,
   input logic              rvalid,
   input logic              rready,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        rresp,
   input logic              rlast
);
   logic b_err, r_err;
   assign b_err = bresp[1] || (STRICT_OKAY && bresp[0]);
   assign r_err = rresp[1] || (STRICT_OKAY && rresp[0]);

   p_launch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> awvalid && wvalid && wlast && awlen == 8'd0);

   p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid && $stable(awaddr));
   p_w_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> wvalid && $stable(wdata));
   p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid && $stable(araddr));

   p_read_after_bresp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arvalid) |-> $past(bvalid && bready));

   p_bready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bready |-> !awvalid && !wvalid);
   p_rready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rready |-> !arvalid);

   p_write_after_rlast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awvalid) |-> ($past(start && !busy) || $past(rvalid && rready && rlast)));

   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && rready && rlast |=> rd_data == $past(rdata));

   p_berr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && bready && b_err |=> done && err && !arvalid && !awvalid);
   p_rerr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && rready && rlast && r_err |=> done && err && !awvalid && !wvalid);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> !err);

   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start && busy |=> $stable(awaddr));
endmodule

bind ordered_wrw_seq wrw_seq_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .STRICT_OKAY (STRICT_OKAY)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .rd_data (rd_data),
   .awvalid (awvalid),
   .awready (awready),
   .awaddr  (awaddr),
   .awlen   (awlen),
   .wvalid  (wvalid),
   .wready  (wready),
   .wdata   (wdata),
   .wlast   (wlast),
   .bvalid  (bvalid),
   .bready  (bready),
   .bresp   (bresp),
   .arvalid (arvalid),
   .arready (arready),
   .araddr  (araddr),
   .rvalid  (rvalid),
   .rready  (rready),
   .rdata   (rdata),
   .rresp   (rresp),
   .rlast   (rlast)
);

// File: tb/tb_ordered_wrw_seq.sv
module tb_ordered_wrw_seq;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int SW = DW / 8;
   localparam int EV_AW = 1, EV_W = 2, EV_B = 3, EV_AR = 4, EV_R = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [DW-1:0] wval_first = '0, wval_second = '0;
   logic [SW-1:0] wmask = '0;
   logic          busy, done, err;
   logic [DW-1:0] rd_data;
   logic          awvalid, wvalid, bready, arvalid, rready, wlast;
   logic          awready = 1'b0, wready = 1'b0, bvalid = 1'b0, arready = 1'b0, rvalid = 1'b0, rlast = 1'b0;
   logic [AW-1:0] awaddr, araddr;
   logic [7:0]    awlen, arlen;
   logic [2:0]    awsize, arsize;
   logic [1:0]    awburst, arburst;
   logic [DW-1:0] wdata;
   logic [SW-1:0] wstrb;
   logic [1:0]    bresp = 2'b00, rresp = 2'b00;
   logic [DW-1:0] rdata = '0;

   ordered_wrw_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .wval_first(wval_first), .wval_second(wval_second), .wmask(wmask),
      .busy(busy), .done(done), .err(err), .rd_data(rd_data),
      .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
      .awsize(awsize), .awburst(awburst),
      .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
      .bvalid(bvalid), .bready(bready), .bresp(bresp),
      .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
      .arsize(arsize), .arburst(arburst),
      .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   // slave model configuration and log
   int dly_aw = 0, dly_w = 0, dly_b = 0, dly_ar = 0, dly_r = 0;
   logic [1:0]    bresp_cfg [2];
   logic [1:0]    rresp_cfg = 2'b00;
   logic [DW-1:0] rdata_cfg = '0;
   int ev [32];
   int n_ev = 0, n_aw = 0, n_w = 0, n_b = 0, n_ar = 0, n_r = 0;
   int meta_bad = 0, order_bad = 0, stab_bad = 0;
   logic [AW-1:0] wr_addr [2];
   logic [DW-1:0] wr_data [2];
   logic [SW-1:0] wr_strb [2];
   logic [AW-1:0] rd_addr;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int find_ev(input int code, input int nth);
      int seen = 0;
      for (int i = 0; i < n_ev; i++)
         if (ev[i] == code) begin
            if (seen == nth) return i;
            seen++;
         end
      return 99;
   endfunction

   function automatic void log_ev(input int code);
      if (n_ev < 32) ev[n_ev] = code;
      n_ev++;
   endfunction

   // slave model: all driving at the falling edge
   initial begin : slave
      bit hs_aw = 0, hs_w = 0, hs_b = 0, hs_ar = 0, hs_r = 0;
      bit pend_aw = 0, pend_w = 0, pend_ar = 0, aw_got = 0, w_got = 0, ar_got = 0;
      int c_aw = 0, c_w = 0, c_b = 0, c_ar = 0, c_r = 0;
      logic [AW-1:0] l_awaddr = '0, l_araddr = '0;
      logic [DW-1:0] l_wdata = '0;
      logic [SW-1:0] l_wstrb = '0;
      logic [7:0] l_awlen = 0, l_arlen = 0;
      logic [2:0] l_awsize = 0, l_arsize = 0;
      logic [1:0] l_awburst = 0, l_arburst = 0;
      logic l_wlast = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            hs_aw = 0; hs_w = 0; hs_b = 0; hs_ar = 0; hs_r = 0;
            pend_aw = 0; pend_w = 0; pend_ar = 0;
            continue;
         end
         if (hs_aw) begin
            awready = 0; log_ev(EV_AW); if (n_aw < 2) wr_addr[n_aw] = l_awaddr;
            if (l_awlen != 0 || l_awsize != 3'd2 || l_awburst != 2'b01) meta_bad++;
            n_aw++; aw_got = 1; c_aw = 0;
         end
         if (hs_w) begin
            wready = 0; log_ev(EV_W);
            if (n_w < 2) begin wr_data[n_w] = l_wdata; wr_strb[n_w] = l_wstrb; end
            if (!l_wlast) meta_bad++;
            n_w++; w_got = 1; c_w = 0;
         end
         if (hs_b)  begin bvalid = 0; log_ev(EV_B); n_b++; end
         if (hs_ar) begin
            arready = 0; log_ev(EV_AR); rd_addr = l_araddr;
            if (l_arlen != 0 || l_arsize != 3'd2 || l_arburst != 2'b01) meta_bad++;
            n_ar++; ar_got = 1; c_ar = 0;
         end
         if (hs_r)  begin rvalid = 0; rlast = 0; log_ev(EV_R); n_r++; end
         // stability of pending requests
         if (pend_aw && (!awvalid || awaddr != l_awaddr)) stab_bad++;
         if (pend_w  && (!wvalid  || wdata  != l_wdata))  stab_bad++;
         if (pend_ar && (!arvalid || araddr != l_araddr)) stab_bad++;
         // ready generation
         if (awvalid && !awready && !aw_got) begin
            if (c_aw >= dly_aw) awready = 1; else c_aw++;
         end
         if (wvalid && !wready && !w_got) begin
            if (c_w >= dly_w) wready = 1; else c_w++;
         end
         if (arvalid && !arready && !ar_got) begin
            if (c_ar >= dly_ar) arready = 1; else c_ar++;
         end
         if (aw_got && w_got && !bvalid) begin
            if (c_b >= dly_b) begin
               bvalid = 1; bresp = bresp_cfg[n_b % 2]; aw_got = 0; w_got = 0; c_b = 0;
            end else c_b++;
         end
         if (ar_got && !rvalid) begin
            if (c_r >= dly_r) begin
               rvalid = 1; rlast = 1; rdata = rdata_cfg; rresp = rresp_cfg; ar_got = 0; c_r = 0;
            end else c_r++;
         end
         if (bready && (awvalid || wvalid)) order_bad++;
         if (rready && arvalid) order_bad++;
         // handshakes that the next rising edge will complete
         hs_aw = awvalid && awready; pend_aw = awvalid && !awready;
         hs_w  = wvalid && wready;   pend_w  = wvalid && !wready;
         hs_ar = arvalid && arready; pend_ar = arvalid && !arready;
         hs_b  = bvalid && bready;
         hs_r  = rvalid && rready && rlast;
         l_awaddr = awaddr; l_awlen = awlen; l_awsize = awsize; l_awburst = awburst;
         l_wdata = wdata; l_wstrb = wstrb; l_wlast = wlast;
         l_araddr = araddr; l_arlen = arlen; l_arsize = arsize; l_arburst = arburst;
      end
   end

   task automatic clear_log();
      n_ev = 0; n_aw = 0; n_w = 0; n_b = 0; n_ar = 0; n_r = 0;
      meta_bad = 0; order_bad = 0; stab_bad = 0;
      for (int i = 0; i < 32; i++) ev[i] = 0;
   endtask

   task automatic set_slave(input int d_aw, input int d_w, input int d_b, input int d_ar,
                            input int d_r, input logic [1:0] b0, input logic [1:0] b1,
                            input logic [1:0] rr, input logic [DW-1:0] rd);
      dly_aw = d_aw; dly_w = d_w; dly_b = d_b; dly_ar = d_ar; dly_r = d_r;
      bresp_cfg[0] = b0; bresp_cfg[1] = b1; rresp_cfg = rr; rdata_cfg = rd;
   endtask

   // pulse start, wait for done; checks busy/done timing (R9)
   task automatic run_seq(input logic [AW-1:0] a, input logic [DW-1:0] v0,
                          input logic [DW-1:0] v1, input logic [SW-1:0] m, input int ignore_at);
      int cyc = 0;
      @(negedge clk);
      start = 1; start_addr = a; wval_first = v0; wval_second = v1; wmask = m;
      @(negedge clk);
      start = 0;
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      while (!done && cyc < 500) begin
         if (cyc == ignore_at) begin
            start = 1; start_addr = a ^ 32'hFFFF_0000; wval_first = ~v0; wval_second = ~v1;
         end else start = 0;
         @(negedge clk);
         cyc++;
      end
      start = 0;
      chk(done == 1'b1, "R9", "done reached", done, 1);
      chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle", done, 0);
      repeat (4) @(negedge clk);
      chk(meta_bad == 0, "R2", "len/size/burst/last fields", meta_bad, 0);
      chk(stab_bad == 0, "R3", "valid payload stability", stab_bad, 0);
      chk(order_bad == 0, "R5", "response ready overlap", order_bad, 0);
   endtask

   task automatic check_full(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] v0,
                             input logic [DW-1:0] v1, input logic [SW-1:0] m, input logic [DW-1:0] rd);
      chk(n_aw == 2 && n_w == 2, "R6", {tag, " two writes"}, n_aw, 2);
      chk(wr_addr[0] == a && wr_data[0] == v0 && wr_strb[0] == m, "R2", {tag, " first write"}, wr_data[0], v0);
      chk(wr_addr[1] == a && wr_data[1] == v1 && wr_strb[1] == m, "R6", {tag, " second write"}, wr_data[1], v1);
      chk(n_ar == 1 && rd_addr == a, "R4", {tag, " read address"}, rd_addr, a);
      chk(find_ev(EV_B, 0) < find_ev(EV_AR, 0), "R4", {tag, " AR after first B"}, find_ev(EV_AR, 0), find_ev(EV_B, 0) + 1);
      chk(find_ev(EV_R, 0) < find_ev(EV_AW, 1) && find_ev(EV_R, 0) < find_ev(EV_W, 1), "R6",
          {tag, " second write after R"}, find_ev(EV_AW, 1), find_ev(EV_R, 0) + 1);
      chk(rd_data == rd, "R7", {tag, " read data"}, rd_data, rd);
   endtask

   task automatic t_reset();
      chk(!awvalid && !wvalid && !arvalid && !bready && !rready, "R1", "valids/readies in reset",
          {awvalid, wvalid, arvalid, bready, rready}, 0);
      chk(!busy && !done && !err, "R1", "status in reset", {busy, done, err}, 0);
   endtask

   task automatic t_basic();
      clear_log();
      set_slave(0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 32'hCAFE_0001);
      run_seq(32'h0000_1000, 32'h1111_2222, 32'h3333_4444, 4'hF, -1);
      check_full("basic", 32'h0000_1000, 32'h1111_2222, 32'h3333_4444, 4'hF, 32'hCAFE_0001);
      chk(err == 1'b0, "R8", "basic no error", err, 0);
   endtask

   task automatic t_slow();
      clear_log();
      set_slave(3, 1, 4, 2, 5, 2'b00, 2'b00, 2'b00, 32'h5A5A_A5A5);
      run_seq(32'h0000_2004, 32'hAAAA_0000, 32'h0000_BBBB, 4'b0110, -1);
      check_full("slow", 32'h0000_2004, 32'hAAAA_0000, 32'h0000_BBBB, 4'b0110, 32'h5A5A_A5A5);
      chk(err == 1'b0, "R10", "err cleared by new start", err, 1'b0);
   endtask

   task automatic t_berr_first();
      clear_log();
      set_slave(0, 2, 1, 0, 0, 2'b10, 2'b00, 2'b00, 32'h0);
      run_seq(32'h0000_3000, 32'h1, 32'h2, 4'h3, -1);
      chk(err == 1'b1, "R8", "B error sets err", err, 1);
      chk(n_ar == 0, "R8", "no read after B error", n_ar, 0);
      chk(n_aw == 1, "R8", "no second write after B error", n_aw, 1);
      repeat (5) @(negedge clk);
      chk(err == 1'b1, "R10", "err held while idle", err, 1);
   endtask

   task automatic t_rerr();
      clear_log();
      set_slave(1, 0, 0, 1, 2, 2'b00, 2'b00, 2'b01, 32'hDEAD_BEEF);
      run_seq(32'h0000_4008, 32'h77, 32'h88, 4'h1, -1);
      chk(err == 1'b1, "R8", "EXOKAY read counts as error", err, 1);
      chk(n_aw == 1 && n_w == 1, "R8", "no second write after R error", n_aw, 1);
      chk(rd_data == 32'hDEAD_BEEF, "R7", "read data kept on error", rd_data, 32'hDEAD_BEEF);
   endtask

   task automatic t_berr_second();
      clear_log();
      set_slave(0, 0, 2, 0, 0, 2'b00, 2'b11, 2'b00, 32'h0BAD_F00D);
      run_seq(32'h0000_500C, 32'h10, 32'h20, 4'hC, -1);
      chk(err == 1'b1, "R8", "second B error", err, 1);
      chk(n_aw == 2 && wr_data[1] == 32'h20, "R6", "second write issued", wr_data[1], 32'h20);
      chk(rd_data == 32'h0BAD_F00D, "R7", "read data after second B error", rd_data, 32'h0BAD_F00D);
   endtask

   task automatic t_start_busy();
      int ev_before;
      clear_log();
      set_slave(2, 2, 3, 2, 3, 2'b00, 2'b00, 2'b00, 32'h1357_9BDF);
      run_seq(32'h0000_6010, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'hA, 4);
      check_full("busy-start", 32'h0000_6010, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'hA, 32'h1357_9BDF);
      ev_before = n_ev;
      repeat (10) @(negedge clk);
      chk(n_ev == ev_before && !busy, "R11", "no extra transaction after ignored start", n_ev, ev_before);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      bresp_cfg[0] = 2'b00; bresp_cfg[1] = 2'b00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_berr_first();
      t_slow();
      t_rerr();
      t_berr_second();
      t_start_busy();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule